// File: doc/BRIEF.md
# Cascadable SEC-DED Memory Error Detection and Correction Slice

This slice guards a 32-bit memory word with a modified Hamming code. On the write side it produces checkbits from system data. On the read side it compares memory data against stored checkbits, forms a syndrome, flips a single wrong data bit and flags errors. One slice covers a 32-bit word with seven checkbits. Two slices cover a 64-bit word with eight checkbits: the lower slice passes partial results to the upper slice, and the upper slice returns the final syndrome.

A slice role code picks one of four behaviours: standalone, lower half, upper half, or a checkbit generator that does no checking. A mode input can turn correction off while detection keeps running. Memory data with its checkbits, and system data, each go through a flow-through hold stage. While its enable is high the stage is transparent. While the enable is low it holds the value captured at the last clock edge.

Top module: `edc_slice`

## Requirements
- R1: Code columns. Data bit i is assigned the i-th value, in ascending numeric order, among nonzero codes of the checkbit width that have odd weight of at least 3 (width 7 standalone, 8 in cascade). In role 00, cb_o[6:0] is the XOR of the columns of all set bits of system data, with bits 2 and 3 inverted (mask 8'h0C), and cb_o[7] is 0.
- R2: In role 00, syn_o is the checkbits generated from memory data XOR mem_cb_i[6:0], with syn_o[7]=0. A zero syndrome keeps err_o and merr_o low, and data_o equals memory data.
- R3: A single flipped memory data bit is corrected on data_o when correction is enabled. syn_o equals that bit's column, err_o=1 and merr_o=0.
- R4: A single flipped checkbit leaves data_o equal to memory data, with err_o=1 and merr_o=0.
- R5: Any two flipped code bits give err_o=1 and merr_o=1, and data_o is left uncorrected. merr_o is never high without err_o.
- R6: Correction runs only when mode_i[1:0]=2'b11. Any other value still detects and flags errors but passes data unchanged. mode_i[2] has no effect.
- R7: Each hold stage passes its input while its enable is high. While the enable is low it presents the value captured at the last clock edge on which the enable was high. Reset clears the held value.
- R8: In role 10 (lower half), cb_o is the raw XOR of cascade columns 0..31 over system data, and syn_o is the same over memory data, both without inversion. mem_cb_i carries the final syndrome, which drives correction and flags.
- R9: In role 11 (upper half), cb_o = part_cb_i ^ raw(system data, columns 32..63) ^ 8'h0C and syn_o = part_cb_i ^ raw(memory data, columns 32..63) ^ 8'h0C ^ mem_cb_i. The slice corrects its own bits, and it flags errors using the whole 64-bit code.
- R10: In role 01 (generate only), cb_o is formed as in R9. syn_o=0, err_o=0 and merr_o=0, and data_o equals memory data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold stages |
| rst | input | 1 | Synchronous active-high reset |
| sys_data_i | input | 32 | System-side data for checkbit generation |
| sys_le_i | input | 1 | System data hold-stage enable |
| mem_data_i | input | 32 | Memory-side data to check |
| mem_cb_i | input | 8 | Stored checkbits, or the final syndrome in the lower role |
| mem_le_i | input | 1 | Memory data and checkbit hold-stage enable |
| part_cb_i | input | 8 | Partial result from the lower slice |
| slice_id_i | input | 2 | Role: 00 solo, 01 generate only, 10 lower, 11 upper |
| mode_i | input | 3 | Mode select; [1:0]=11 corrects |
| cb_o | output | 8 | Checkbits or partial checkbits |
| syn_o | output | 8 | Syndrome or partial syndrome |
| data_o | output | 32 | Corrected or passed-through memory data |
| err_o | output | 1 | Any error detected |
| merr_o | output | 1 | Uncorrectable multi-bit error |

## Verification
The bench flips every one of the 39 code bits in turn. A decoder with a wrong column table would repair the wrong bit, and one that treated checkbit errors as data errors would corrupt clean data. Sampled double flips must raise the multi-bit flag without touching the data, so a design that matched even-weight syndromes to columns would fail those checks. The bench also runs a two-slice cascade with flips in each half and across both halves, which exposes a slice that decides correctability from its own half only. It checks that the parity inversion of bits 2 and 3 lands only on final checkbits and never on lower partials, and that a hold stage with its enable low ignores new input.

// File: rtl/edc_pkg.sv
package edc_pkg;
    localparam int DATA_W    = 32;
    localparam int CB_W      = 8;
    localparam int SOLO_CB_W = 7;
    localparam int WIDE_COLS = 2 * DATA_W;
    localparam logic [CB_W-1:0] CB_INVERT = 8'b0000_1100;

    typedef logic [CB_W-1:0] cb_t;
    typedef cb_t [WIDE_COLS-1:0] colset_t;

    typedef enum logic [1:0] {
        ROLE_SOLO     = 2'b00,
        ROLE_GEN_ONLY = 2'b01,
        ROLE_LOWER    = 2'b10,
        ROLE_UPPER    = 2'b11
    } role_e;

    typedef struct packed {
        cb_t solo;
        cb_t lower;
        cb_t upper;
    } parity_set_t;

    function automatic int bit_weight(int v);
        int n = 0;
        for (int b = 0; b < CB_W; b++) n += (v >> b) & 1;
        return n;
    endfunction

    // ascending odd-weight (>=3) codes that fit in w bits
    function automatic colset_t build_cols(int w);
        colset_t c = '0;
        int k = 0;
        for (int v = 1; v < (1 << CB_W); v++) begin
            if (v < (1 << w) && bit_weight(v) >= 3 && (bit_weight(v) % 2) == 1
                && k < WIDE_COLS) begin
                c[k] = cb_t'(v);
                k++;
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/edc_flow_latch.sv
module edc_flow_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)       held_q <= '0;
        else if (le_i) held_q <= d_i;
    end

    assign q_o = le_i ? d_i : held_q;

    a_r7_hold_steady: assert property (@(posedge clk) disable iff (rst)
        !le_i |=> (rst || $stable(held_q)));
endmodule

// File: rtl/edc_parity_gen.sv
module edc_parity_gen
    import edc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output parity_set_t       par_o
);
    localparam colset_t SOLO_COLS = build_cols(SOLO_CB_W);
    localparam colset_t WIDE_COLS_T = build_cols(CB_W);

    always_comb begin
        par_o = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (data_i[i]) begin
                par_o.solo  = par_o.solo  ^ SOLO_COLS[i];
                par_o.lower = par_o.lower ^ WIDE_COLS_T[i];
                par_o.upper = par_o.upper ^ WIDE_COLS_T[i + DATA_W];
            end
        end
    end
endmodule

// File: rtl/edc_syn_decode.sv
module edc_syn_decode
    import edc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cb_t               syn_i,
    input  logic              wide_i,
    input  logic              upper_i,
    input  logic              corr_en_i,
    output logic [DATA_W-1:0] flip_o,
    output logic              err_o,
    output logic              merr_o
);
    localparam colset_t SOLO_COLS = build_cols(SOLO_CB_W);
    localparam colset_t WIDE_COLS_T = build_cols(CB_W);

    logic hit;
    cb_t  col;

    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < WIDE_COLS; k++) begin
            if (wide_i && syn_i == WIDE_COLS_T[k]) hit = 1'b1;
            if (!wide_i && k < DATA_W && syn_i == SOLO_COLS[k]) hit = 1'b1;
        end
        flip_o = '0;
        col    = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (!wide_i)      col = SOLO_COLS[i];
            else if (upper_i) col = WIDE_COLS_T[i + DATA_W];
            else              col = WIDE_COLS_T[i];
            flip_o[i] = corr_en_i && (syn_i != '0) && (syn_i == col);
        end
        err_o  = |syn_i;
        merr_o = err_o && !hit && (bit_weight(int'(syn_i)) != 1);
    end

    a_r3_one_flip_max: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flip_o));
    a_r5_merr_needs_err: assert property (@(posedge clk) disable iff (rst)
        merr_o |-> err_o);
    a_r2_clean_quiet: assert property (@(posedge clk) disable iff (rst)
        (syn_i == '0) |-> (!err_o && flip_o == '0));
    a_r4_cb_error_no_flip: assert property (@(posedge clk) disable iff (rst)
        ($countones(syn_i) == 1) |-> (flip_o == '0 && !merr_o));
endmodule

// File: rtl/edc_slice.sv
module edc_slice
    import edc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] sys_data_i,
    input  logic              sys_le_i,
    input  logic [DATA_W-1:0] mem_data_i,
    input  logic [CB_W-1:0]   mem_cb_i,
    input  logic              mem_le_i,
    input  logic [CB_W-1:0]   part_cb_i,
    input  logic [1:0]        slice_id_i,
    input  logic [2:0]        mode_i,
    output logic [CB_W-1:0]   cb_o,
    output logic [CB_W-1:0]   syn_o,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o,
    output logic              merr_o
);
    localparam int MEM_W = DATA_W + CB_W;

    role_e             role;
    logic [DATA_W-1:0] sd_q;
    logic [DATA_W-1:0] md_q;
    cb_t               cb_q;
    logic [MEM_W-1:0]  mem_q;
    parity_set_t       sd_par;
    parity_set_t       md_par;
    cb_t               dec_syn;
    logic              wide;
    logic              corr_en;
    logic [DATA_W-1:0] flip;
    logic              mode_hi_unused;

    assign role           = role_e'(slice_id_i);
    assign mode_hi_unused = mode_i[2];

    edc_flow_latch #(.W(DATA_W)) u_sys_hold (
        .clk(clk), .rst(rst), .le_i(sys_le_i), .d_i(sys_data_i), .q_o(sd_q)
    );
    edc_flow_latch #(.W(MEM_W)) u_mem_hold (
        .clk(clk), .rst(rst), .le_i(mem_le_i), .d_i({mem_cb_i, mem_data_i}), .q_o(mem_q)
    );
    assign md_q = mem_q[DATA_W-1:0];
    assign cb_q = mem_q[MEM_W-1:DATA_W];

    edc_parity_gen u_sys_gen (.data_i(sd_q), .par_o(sd_par));
    edc_parity_gen u_mem_gen (.data_i(md_q), .par_o(md_par));

    always_comb begin
        cb_o    = '0;
        syn_o   = '0;
        dec_syn = '0;
        wide    = 1'b1;
        unique case (role)
            ROLE_SOLO: begin
                wide    = 1'b0;
                cb_o    = sd_par.solo ^ CB_INVERT;
                syn_o   = md_par.solo ^ CB_INVERT ^ {1'b0, cb_q[SOLO_CB_W-1:0]};
                dec_syn = syn_o;
            end
            ROLE_GEN_ONLY: begin
                cb_o = part_cb_i ^ sd_par.upper ^ CB_INVERT;
            end
            ROLE_LOWER: begin
                cb_o    = sd_par.lower;
                syn_o   = md_par.lower;
                dec_syn = cb_q;
            end
            ROLE_UPPER: begin
                cb_o    = part_cb_i ^ sd_par.upper ^ CB_INVERT;
                syn_o   = part_cb_i ^ md_par.upper ^ CB_INVERT ^ cb_q;
                dec_syn = syn_o;
            end
            default: ;
        endcase
    end

    assign corr_en = (mode_i[1:0] == 2'b11) && (role != ROLE_GEN_ONLY);

    edc_syn_decode u_decode (
        .clk(clk), .rst(rst), .syn_i(dec_syn), .wide_i(wide),
        .upper_i(role == ROLE_UPPER), .corr_en_i(corr_en),
        .flip_o(flip), .err_o(err_o), .merr_o(merr_o)
    );

    assign data_o = md_q ^ flip;

    a_r6_detect_only_passes: assert property (@(posedge clk) disable iff (rst)
        (mode_i[1:0] != 2'b11) |-> (data_o == md_q));
    a_r10_gen_only_quiet: assert property (@(posedge clk) disable iff (rst)
        (role == ROLE_GEN_ONLY) |-> (!err_o && !merr_o && syn_o == '0));
endmodule

// File: tb/edc_slice_test.sv
module edc_slice_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] sd = '0, md = '0, sd_hi = '0, md_hi = '0;
    logic        sd_le = 1'b0, md_le = 1'b0;
    logic [7:0]  cb = '0, part = '0;
    logic [1:0]  id_lo = 2'b00;
    logic [2:0]  mode = 3'b011;
    logic        casc = 1'b0, casc_rd = 1'b0;

    logic [7:0]  lo_cb, lo_syn, hi_cb, hi_syn, lo_cbi, hi_part;
    logic [31:0] lo_data, hi_data;
    logic        lo_err, lo_merr, hi_err, hi_merr;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    assign lo_cbi  = casc ? hi_syn : cb;
    assign hi_part = casc_rd ? lo_syn : lo_cb;

    edc_slice uut (
        .clk(clk), .rst(rst), .sys_data_i(sd), .sys_le_i(sd_le),
        .mem_data_i(md), .mem_cb_i(lo_cbi), .mem_le_i(md_le),
        .part_cb_i(part), .slice_id_i(id_lo), .mode_i(mode),
        .cb_o(lo_cb), .syn_o(lo_syn), .data_o(lo_data),
        .err_o(lo_err), .merr_o(lo_merr)
    );
    edc_slice uut_hi (
        .clk(clk), .rst(rst), .sys_data_i(sd_hi), .sys_le_i(sd_le),
        .mem_data_i(md_hi), .mem_cb_i(cb), .mem_le_i(md_le),
        .part_cb_i(hi_part), .slice_id_i(2'b11), .mode_i(mode),
        .cb_o(hi_cb), .syn_o(hi_syn), .data_o(hi_data),
        .err_o(hi_err), .merr_o(hi_merr)
    );

    function automatic logic [7:0] bcol(int w, int idx);
        int k = 0;
        for (int v = 1; v < 256; v++) begin
            int ones = 0;
            for (int b = 0; b < 8; b++) if (v[b]) ones++;
            if (v < (1 << w) && ones >= 3 && ones[0]) begin
                if (k == idx) return v[7:0];
                k++;
            end
        end
        return 8'h00;
    endfunction

    function automatic logic [7:0] braw(logic [63:0] d, int n, int w, int base);
        logic [7:0] r = '0;
        for (int i = 0; i < n; i++) if (d[i]) r ^= bcol(w, base + i);
        return r;
    endfunction

    function automatic logic [7:0] enc32(logic [31:0] d);
        return braw({32'h0, d}, 32, 7, 0) ^ 8'h0C;
    endfunction

    function automatic logic [7:0] enc64(logic [63:0] d);
        return braw(d, 64, 8, 0) ^ 8'h0C;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [31:0] d, logic [7:0] c);
        @(negedge clk);
        md = d;
        cb = c;
        #5;
    endtask

    // R7: reset clears the hold stages
    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        chk("R7 reset data", {32'h0, lo_data}, 64'h0);
        chk("R7 reset checkbits", {56'h0, lo_cb}, {56'h0, 8'h0C});
        @(negedge clk);
        sd_le = 1'b1;
        md_le = 1'b1;
    endtask

    // R1: checkbit generation
    task automatic t_encode();
        logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_1234, 32'h0000_0001};
        foreach (pats[p]) begin
            @(negedge clk);
            sd = pats[p];
            #5;
            chk("R1 solo checkbits", {56'h0, lo_cb}, {56'h0, enc32(pats[p])});
        end
    endtask

    // R2: clean word
    task automatic t_clean();
        drive(32'hDEAD_BEEF, enc32(32'hDEAD_BEEF));
        chk("R2 clean data", {32'h0, lo_data}, {32'h0, 32'hDEAD_BEEF});
        chk("R2 clean syndrome", {56'h0, lo_syn}, 64'h0);
        chk("R2 clean flags", {62'h0, lo_err, lo_merr}, 64'h0);
    endtask

    // R3 / R4: every single flip over 39 code bits
    task automatic t_single(logic [31:0] d);
        logic [7:0] c = enc32(d);
        for (int j = 0; j < 39; j++) begin
            if (j < 32) begin
                drive(d ^ (32'h1 << j), c);
                chk("R3 corrected data", {32'h0, lo_data}, {32'h0, d});
                chk("R3 syndrome column", {56'h0, lo_syn}, {56'h0, bcol(7, j)});
                chk("R3 flags", {62'h0, lo_err, lo_merr}, 64'h2);
            end else begin
                drive(d, c ^ (8'h1 << (j - 32)));
                chk("R4 data untouched", {32'h0, lo_data}, {32'h0, d});
                chk("R4 flags", {62'h0, lo_err, lo_merr}, 64'h2);
            end
        end
    endtask

    // R5: sampled double flips
    task automatic t_double(logic [31:0] d);
        logic [7:0] c = enc32(d);
        for (int j = 0; j < 38; j += 3) begin
            for (int k = j + 1; k < 39; k += 7) begin
                logic [38:0] word = {c[6:0], d};
                word[j] = ~word[j];
                word[k] = ~word[k];
                drive(word[31:0], {1'b0, word[38:32]});
                chk("R5 double flags", {62'h0, lo_err, lo_merr}, 64'h3);
                chk("R5 data not altered", {32'h0, lo_data}, {32'h0, word[31:0]});
            end
        end
    endtask

    // R6: correction gating by mode
    task automatic t_mode();
        logic [31:0] d = 32'h1357_9BDF;
        logic [31:0] bad = d ^ 32'h0000_0200;
        mode = 3'b010;
        drive(bad, enc32(d));
        chk("R6 detect-only data", {32'h0, lo_data}, {32'h0, bad});
        chk("R6 detect-only err", {63'h0, lo_err}, 64'h1);
        mode = 3'b000;
        drive(bad, enc32(d));
        chk("R6 mode 000 data", {32'h0, lo_data}, {32'h0, bad});
        mode = 3'b111;
        drive(bad, enc32(d));
        chk("R6 mode 111 corrects", {32'h0, lo_data}, {32'h0, d});
        chk("R6 mode 111 syndrome", {56'h0, lo_syn}, {56'h0, bcol(7, 9)});
        mode = 3'b011;
    endtask

    // R7: hold behaviour
    task automatic t_hold();
        drive(32'h0F0F_0F0F, enc32(32'h0F0F_0F0F));
        sd = 32'h1111_2222;
        @(negedge clk);
        md_le = 1'b0;
        sd_le = 1'b0;
        md = 32'hFFFF_0000;
        cb = 8'h55;
        sd = 32'h3333_4444;
        #5;
        chk("R7 held memory data", {32'h0, lo_data}, {32'h0, 32'h0F0F_0F0F});
        chk("R7 held flags", {62'h0, lo_err, lo_merr}, 64'h0);
        chk("R7 held system data", {56'h0, lo_cb}, {56'h0, enc32(32'h1111_2222)});
        @(negedge clk);
        #5;
        chk("R7 still held", {32'h0, lo_data}, {32'h0, 32'h0F0F_0F0F});
        @(negedge clk);
        md_le = 1'b1;
        sd_le = 1'b1;
        #5;
        chk("R7 transparent again", {56'h0, lo_cb}, {56'h0, enc32(32'h3333_4444)});
    endtask

    // R8 / R9: two-slice cascade
    task automatic t_cascade();
        logic [63:0] w = 64'h0123_4567_89AB_CDEF;
        logic [63:0] s = 64'hFEDC_BA98_7654_3210;
        logic [7:0]  c = enc64(w);
        id_lo = 2'b10;
        casc = 1'b1;
        casc_rd = 1'b0;
        @(negedge clk);
        sd = s[31:0];
        sd_hi = s[63:32];
        #5;
        chk("R8 lower partial checkbits", {56'h0, lo_cb}, {56'h0, braw(s, 32, 8, 0)});
        chk("R9 final checkbits", {56'h0, hi_cb}, {56'h0, enc64(s)});
        casc_rd = 1'b1;
        @(negedge clk);
        md = w[31:0];
        md_hi = w[63:32];
        cb = c;
        #5;
        chk("R8 lower partial syndrome", {56'h0, lo_syn}, {56'h0, braw(w, 32, 8, 0)});
        chk("R9 clean final syndrome", {56'h0, hi_syn}, 64'h0);
        chk("R9 clean flags", {60'h0, lo_err, lo_merr, hi_err, hi_merr}, 64'h0);
        @(negedge clk);
        md = w[31:0] ^ 32'h80;
        #5;
        chk("R8 lower bit corrected", {32'h0, lo_data}, {32'h0, w[31:0]});
        chk("R9 upper untouched", {32'h0, hi_data}, {32'h0, w[63:32]});
        chk("R9 syndrome lower flip", {56'h0, hi_syn}, {56'h0, bcol(8, 7)});
        chk("R8 single flags", {60'h0, lo_err, lo_merr, hi_err, hi_merr}, 64'hA);
        @(negedge clk);
        md = w[31:0];
        md_hi = w[63:32] ^ 32'h0010_0000;
        #5;
        chk("R9 upper bit corrected", {32'h0, hi_data}, {32'h0, w[63:32]});
        chk("R8 lower untouched", {32'h0, lo_data}, {32'h0, w[31:0]});
        chk("R9 syndrome upper flip", {56'h0, hi_syn}, {56'h0, bcol(8, 52)});
        @(negedge clk);
        md = w[31:0] ^ 32'h8;
        md_hi = w[63:32] ^ 32'h10;
        #5;
        chk("R5 cross-half double", {60'h0, lo_err, lo_merr, hi_err, hi_merr}, 64'hF);
        chk("R5 cross-half data kept", {lo_data, hi_data}, {w[31:0] ^ 32'h8, w[63:32] ^ 32'h10});
        casc = 1'b0;
        casc_rd = 1'b0;
    endtask

    // R10: generate-only role
    task automatic t_gen_only();
        id_lo = 2'b01;
        @(negedge clk);
        part = 8'h5A;
        sd = 32'hCAFE_F00D;
        md = 32'h1234_5678;
        cb = 8'hFF;
        #5;
        chk("R10 generated checkbits", {56'h0, lo_cb},
            {56'h0, 8'h5A ^ braw({32'h0, 32'hCAFE_F00D}, 32, 8, 32) ^ 8'h0C});
        chk("R10 flags low", {62'h0, lo_err, lo_merr}, 64'h0);
        chk("R10 syndrome zero", {56'h0, lo_syn}, 64'h0);
        chk("R10 data passes", {32'h0, lo_data}, {32'h0, 32'h1234_5678});
        id_lo = 2'b00;
    endtask

    initial begin
        t_reset();
        t_encode();
        t_clean();
        t_single(32'hA5A5_5A5A);
        t_single(32'h0000_0000);
        t_double(32'h89AB_CDEF);
        t_mode();
        t_hold();
        t_cascade();
        t_gen_only();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule